// File: doc/BRIEF.md
# Variable refresh vertical timing controller

This block keeps the vertical scanline count for a display transcoder whose frame length is allowed to vary. While variable refresh is active, a frame keeps stretching its vertical blank until software requests a push or the line count reaches its upper limit. Either event starts an exit sequence of fixed length. On the first line of that sequence the block pulses a register-latch strobe, and when the sequence ends it pulses frame start and the line count returns to zero. While variable refresh is inactive, every frame has the fixed length of the maximum line count.

Software programs five things through a small register port: the shortest frame, the longest frame, a flip line that sets the shortest frame actually produced, an exit length in lines (the guardband), and a control word. The timing fields are double-buffered. A write lands in an armed copy, and the active copy takes that value at the next latch strobe. The enable bit in the control word is not buffered. A live status bit follows it, but only at frame boundaries. This gives software a safe disable handshake: it clears enable, waits for live to read zero, and only then rewrites the other fields. `line_tick` marks the end of each scanline and is the only event that advances the count.

Top module: `vrr_vtiming`

## Requirements
- R1: After reset, `cur_line`, `latch_strobe`, `frame_start` and `vrr_live` are 0. Register reads return these values: control 0x402 (flip-line enable 1, guardband 4), minimum 9, maximum 19, flip 10, push 0, status 0.
- R2: The register map is as follows.
  - 0 is control: bit0 enable, bit1 flip-line enable, bit2 ignore-max-shift, bits[15:8] guardband.
  - 1 is minimum, 2 is maximum and 3 is flip line. Each holds a line count minus one in bits[12:0].
  - 4 is push: bit0 enable, bit1 send.
  - 5 is status: bit0 live, read-only.
  - A read of control, minimum, maximum or flip returns the last value written.
- R3: With no push pending, the latch strobe comes on line (maximum+1−G) and the frame lasts maximum+1 lines. G is the active guardband.
- R4: A push written before the earliest exit line is held pending. Exit then starts on line (flip+1−G), so the frame lasts flip+1 lines.
- R5: A push written while the count is at line p, with p+1 at or above the earliest exit line, starts the exit on line p+1. The frame then lasts p+1+G lines.
- R6: `latch_strobe` and `frame_start` are single-cycle pulses that never coincide. `cur_line` is 0 in the cycle in which `frame_start` is high.
- R7: Writing push with both bit0 and bit1 set, while live, makes bit1 read 1. Bit1 reads 0 again once the exit that consumes the push has started.
- R8: A push written while live is 0 is ignored. Send reads 0 and the frame length stays maximum+1.
- R9: `vrr_live` changes only at a frame boundary, where it takes the value of the enable bit. After enable is cleared, status reads 1 until that boundary.
- R10: Writes to minimum, maximum, flip, flip-line enable and guardband take effect only at the next latch strobe. The frame in which they are written keeps its old timing.
- R11: With flip-line enable at 0, the earliest exit line is (minimum+2−G) and the flip register is not used.
- R12: A guardband of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle pulse at the end of each scanline |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, used for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cur_line | output | 13 | Current scanline within the frame |
| latch_strobe | output | 1 | Pulse on the first line of the exit sequence; the active timing set reloads here |
| frame_start | output | 1 | Pulse when the exit sequence completes |
| vrr_live | output | 1 | Variable refresh currently in effect |

## Verification
A bad exit decision shows up within one frame, because the latch strobe appears on the wrong line and the frame length differs from maximum+1, flip+1 or p+1+G. A wrong stored exit end makes `frame_start` fire early or late, and the per-clock comparison sees this on the first wrong line. A push flag that is wrongly set or cleared shows up at once in the readback of the send bit, and one frame later as a shortened or unshortened frame. A live bit that changes away from a boundary is visible on `vrr_live` in the same cycle.

// File: rtl/vrr_pkg.sv
package vrr_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_VMIN = 3'd1,
    A_VMAX = 3'd2,
    A_FLIP = 3'd3,
    A_PUSH = 3'd4,
    A_STAT = 3'd5
  } reg_addr_e;

  localparam int CTL_EN     = 0;
  localparam int CTL_FE     = 1;
  localparam int CTL_IGN    = 2;
  localparam int CTL_GB_LSB = 8;
  localparam int PSH_EN     = 0;
  localparam int PSH_SEND   = 1;

  typedef enum logic {PH_SCAN, PH_EXIT} phase_e;
endpackage

// File: rtl/vrr_regs.sv
module vrr_regs import vrr_pkg::*; #(
  parameter int LINE_W   = 13,
  parameter int GB_W     = 8,
  parameter int DATA_W   = 32,
  parameter int RST_VMIN = 9,
  parameter int RST_VMAX = 19,
  parameter int RST_FLIP = 10,
  parameter int RST_GB   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              live,
  input  logic              latch_now,
  input  logic              wrap_now,
  output logic [LINE_W-1:0] act_vmin,
  output logic [LINE_W-1:0] act_vmax,
  output logic [LINE_W-1:0] act_flip,
  output logic [GB_W-1:0]   act_gb,
  output logic              act_fe,
  output logic              ctrl_en,
  output logic              push_pend
);
  logic [LINE_W-1:0] arm_vmin, arm_vmax, arm_flip;
  logic [GB_W-1:0]   arm_gb;
  logic              arm_fe, ign_q, push_en_q;
  logic              wr_ctrl, wr_vmin, wr_vmax, wr_flip, wr_push, push_req, live_drop;

  always_comb begin
    wr_ctrl   = wr && (addr == A_CTRL);
    wr_vmin   = wr && (addr == A_VMIN);
    wr_vmax   = wr && (addr == A_VMAX);
    wr_flip   = wr && (addr == A_FLIP);
    wr_push   = wr && (addr == A_PUSH);
    push_req  = wr_push && wdata[PSH_EN] && wdata[PSH_SEND];
    live_drop = wrap_now && !ctrl_en;
  end

  // armed copies and unbuffered control bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_vmin  <= LINE_W'(RST_VMIN);
      arm_vmax  <= LINE_W'(RST_VMAX);
      arm_flip  <= LINE_W'(RST_FLIP);
      arm_gb    <= GB_W'(RST_GB);
      arm_fe    <= 1'b1;
      ctrl_en   <= 1'b0;
      ign_q     <= 1'b0;
      push_en_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en <= wdata[CTL_EN];
        arm_fe  <= wdata[CTL_FE];
        ign_q   <= wdata[CTL_IGN];
        arm_gb  <= wdata[CTL_GB_LSB +: GB_W];
      end
      if (wr_vmin) arm_vmin <= wdata[LINE_W-1:0];
      if (wr_vmax) arm_vmax <= wdata[LINE_W-1:0];
      if (wr_flip) arm_flip <= wdata[LINE_W-1:0];
      if (wr_push) push_en_q <= wdata[PSH_EN];
    end
  end

  // active copies reload at the latch point
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_vmin <= LINE_W'(RST_VMIN);
      act_vmax <= LINE_W'(RST_VMAX);
      act_flip <= LINE_W'(RST_FLIP);
      act_gb   <= GB_W'(RST_GB);
      act_fe   <= 1'b1;
    end else if (latch_now) begin
      act_vmin <= arm_vmin;
      act_vmax <= arm_vmax;
      act_flip <= arm_flip;
      act_gb   <= arm_gb;
      act_fe   <= arm_fe;
    end
  end

  // push request: dropped when live ends, set by software, consumed at exit start
  always_ff @(posedge clk) begin
    if (!rst_n)                 push_pend <= 1'b0;
    else if (live_drop)         push_pend <= 1'b0;
    else if (push_req && live)  push_pend <= 1'b1;
    else if (latch_now)         push_pend <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[CTL_EN]               = ctrl_en;
        rdata[CTL_FE]               = arm_fe;
        rdata[CTL_IGN]              = ign_q;
        rdata[CTL_GB_LSB +: GB_W]   = arm_gb;
      end
      A_VMIN: rdata[LINE_W-1:0] = arm_vmin;
      A_VMAX: rdata[LINE_W-1:0] = arm_vmax;
      A_FLIP: rdata[LINE_W-1:0] = arm_flip;
      A_PUSH: begin
        rdata[PSH_EN]   = push_en_q;
        rdata[PSH_SEND] = push_pend;
      end
      A_STAT: rdata[0] = live;
      default: rdata = '0;
    endcase
  end

  p_push_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_now && !push_req) |=> !push_pend);
  p_push_needs_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !push_pend);
  p_active_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_now |=> ($stable(act_vmax) && $stable(act_flip) && $stable(act_gb)));
endmodule

// File: rtl/vrr_window.sv
module vrr_window #(
  parameter int LINE_W = 13,
  parameter int GB_W   = 8
) (
  input  logic [LINE_W-1:0] act_vmin,
  input  logic [LINE_W-1:0] act_vmax,
  input  logic [LINE_W-1:0] act_flip,
  input  logic [GB_W-1:0]   act_gb,
  input  logic              act_fe,
  output logic [LINE_W-1:0] early_line,
  output logic [LINE_W-1:0] late_line,
  output logic [LINE_W-1:0] gb_eff
);
  localparam logic [LINE_W-1:0] ONE = LINE_W'(1);
  localparam logic [LINE_W-1:0] TWO = LINE_W'(2);
  logic [LINE_W-1:0] shortest;

  always_comb begin
    gb_eff     = (act_gb == '0) ? ONE : LINE_W'(act_gb);
    shortest   = act_fe ? (act_flip + ONE) : (act_vmin + TWO);
    early_line = shortest - gb_eff;
    late_line  = act_vmax + ONE - gb_eff;
  end
endmodule

// File: rtl/vrr_line_engine.sv
module vrr_line_engine import vrr_pkg::*; #(
  parameter int LINE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] early_line,
  input  logic [LINE_W-1:0] late_line,
  input  logic [LINE_W-1:0] gb_eff,
  input  logic              push_pend,
  input  logic              ctrl_en,
  output logic [LINE_W-1:0] line_q,
  output logic              latch_o,
  output logic              frame_o,
  output logic              live_o,
  output logic              start_now,
  output logic              wrap_now
);
  phase_e            phase_q;
  logic [LINE_W-1:0] end_q, nxt;

  always_comb begin
    nxt       = line_q + LINE_W'(1);
    start_now = line_tick && (phase_q == PH_SCAN) &&
                ((nxt >= late_line) || (push_pend && (nxt >= early_line)));
    wrap_now  = line_tick && (phase_q == PH_EXIT) && (nxt == end_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      end_q   <= '0;
      phase_q <= PH_SCAN;
      latch_o <= 1'b0;
      frame_o <= 1'b0;
      live_o  <= 1'b0;
    end else begin
      latch_o <= start_now;
      frame_o <= wrap_now;
      if (line_tick) line_q <= wrap_now ? '0 : nxt;
      if (start_now) begin
        phase_q <= PH_EXIT;
        end_q   <= nxt + gb_eff;
      end
      if (wrap_now) begin
        phase_q <= PH_SCAN;
        live_o  <= ctrl_en;
      end
    end
  end

  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_o && frame_o));
  p_frame_line0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> (line_q == '0));
  p_live_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_now |=> $stable(live_o));
  p_exit_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXIT) |-> (line_q < end_q));
endmodule

// File: rtl/vrr_vtiming.sv
module vrr_vtiming #(
  parameter int LINE_W   = 13,
  parameter int GB_W     = 8,
  parameter int DATA_W   = 32,
  parameter int RST_VMIN = 9,
  parameter int RST_VMAX = 19,
  parameter int RST_FLIP = 10,
  parameter int RST_GB   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        line_tick,
  input  logic                        reg_wr,
  input  logic [vrr_pkg::ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  output logic [LINE_W-1:0]           cur_line,
  output logic                        latch_strobe,
  output logic                        frame_start,
  output logic                        vrr_live
);
  logic [LINE_W-1:0] act_vmin, act_vmax, act_flip, early_line, late_line, gb_eff;
  logic [GB_W-1:0]   act_gb;
  logic              act_fe, ctrl_en, push_pend, start_now, wrap_now;

  vrr_regs #(
    .LINE_W(LINE_W), .GB_W(GB_W), .DATA_W(DATA_W),
    .RST_VMIN(RST_VMIN), .RST_VMAX(RST_VMAX), .RST_FLIP(RST_FLIP), .RST_GB(RST_GB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .live(vrr_live), .latch_now(start_now), .wrap_now(wrap_now),
    .act_vmin(act_vmin), .act_vmax(act_vmax), .act_flip(act_flip), .act_gb(act_gb),
    .act_fe(act_fe), .ctrl_en(ctrl_en), .push_pend(push_pend)
  );

  vrr_window #(.LINE_W(LINE_W), .GB_W(GB_W)) u_window (
    .act_vmin(act_vmin), .act_vmax(act_vmax), .act_flip(act_flip), .act_gb(act_gb),
    .act_fe(act_fe), .early_line(early_line), .late_line(late_line), .gb_eff(gb_eff)
  );

  vrr_line_engine #(.LINE_W(LINE_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .early_line(early_line),
    .late_line(late_line), .gb_eff(gb_eff), .push_pend(push_pend), .ctrl_en(ctrl_en),
    .line_q(cur_line), .latch_o(latch_strobe), .frame_o(frame_start), .live_o(vrr_live),
    .start_now(start_now), .wrap_now(wrap_now)
  );
endmodule

// File: tb/vrr_vtiming_tb.sv
module vrr_vtiming_tb;
  logic        clk = 1'b0, rst_n = 1'b0, line_tick = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [12:0] cur_line;
  logic        latch_strobe, frame_start, vrr_live;

  always #4 clk = ~clk;

  vrr_vtiming u_dut (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_line(cur_line),
    .latch_strobe(latch_strobe), .frame_start(frame_start), .vrr_live(vrr_live)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scanline pacing: one tick every 4 clocks
  int tcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin tcnt = 0; line_tick = 1'b0; end
    else begin line_tick = (tcnt == 3); tcnt = (tcnt + 1) % 4; end
  end

  // behavioural reference model
  int m_line, m_end, a_vmin, a_vmax, a_flip, a_gb, w_vmin, w_vmax, w_flip, w_gb;
  bit m_exit, m_live, m_push, m_en, m_latch, m_fs, a_fe, w_fe;
  always @(posedge clk) begin
    int g, shortest, e, l, n;
    bit st, wp;
    if (!rst_n) begin
      m_line = 0; m_end = 0; m_exit = 0; m_live = 0; m_push = 0; m_en = 0;
      m_latch = 0; m_fs = 0;
      a_vmin = 9; a_vmax = 19; a_flip = 10; a_gb = 4; a_fe = 1;
      w_vmin = 9; w_vmax = 19; w_flip = 10; w_gb = 4; w_fe = 1;
    end else begin
      st = 0; wp = 0;
      g = (a_gb == 0) ? 1 : a_gb;
      shortest = a_fe ? a_flip + 1 : a_vmin + 2;
      e = shortest - g;
      l = a_vmax + 1 - g;
      if (line_tick) begin
        n = m_line + 1;
        if (!m_exit) begin
          if (n >= l || (m_push && n >= e)) begin st = 1; m_exit = 1; m_end = n + g; end
          m_line = n;
        end else if (n == m_end) begin
          wp = 1; m_exit = 0; m_line = 0;
        end else m_line = n;
      end
      if (wp && !m_en) m_push = 0;
      else if (reg_wr && reg_addr == 3'd4 && reg_wdata[1:0] == 2'b11 && m_live) m_push = 1;
      else if (st) m_push = 0;
      if (wp) m_live = m_en;
      if (st) begin
        a_vmin = w_vmin; a_vmax = w_vmax; a_flip = w_flip; a_gb = w_gb; a_fe = w_fe;
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin m_en = reg_wdata[0]; w_fe = reg_wdata[1]; w_gb = int'(reg_wdata[15:8]); end
          3'd1: w_vmin = int'(reg_wdata[12:0]);
          3'd2: w_vmax = int'(reg_wdata[12:0]);
          3'd3: w_flip = int'(reg_wdata[12:0]);
          default: ;
        endcase
      end
      m_latch = st; m_fs = wp;
    end
  end

  // per-clock comparison (R3 R6 R9) and frame measurement
  int prev_line = 0, last_len = 0, last_latch = -1;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 R3 R9 per-clock model {line,latch,fs,live}",
          int'(cur_line) * 8 + int'(latch_strobe) * 4 + int'(frame_start) * 2 + int'(vrr_live),
          m_line * 8 + int'(m_latch) * 4 + int'(m_fs) * 2 + int'(m_live));
      if (frame_start) last_len = prev_line + 1;
      if (latch_strobe) last_latch = int'(cur_line);
      prev_line = int'(cur_line);
    end
  end

  task automatic wr(input int a, input int d);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 3'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic wait_frame();
    do @(negedge clk); while (!frame_start);
    #1;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 cur_line", int'(cur_line), 0);
    chk("R1 pulses/live", int'({latch_strobe, frame_start, vrr_live}), 0);
    rd(0, d); chk("R1 control reset", d, 'h402);
    rd(2, d); chk("R1 maximum reset", d, 19);
    rd(5, d); chk("R1 status reset", d, 0);
    rd(4, d); chk("R1 push reset", d, 0);

    wait_frame();
    wait_frame();
    chk("R3 fixed length", last_len, 20);
    chk("R3 fixed latch line", last_latch, 16);

    wr(4, 3);
    rd(4, d); chk("R8 send ignored when not live", (d >> 1) & 1, 0);
    wait_frame();
    chk("R8 length unchanged", last_len, 20);

    wr(1, 29); wr(3, 30); wr(2, 59); wr(0, 'h603);
    rd(2, d); chk("R2 maximum readback", d, 59);
    rd(0, d); chk("R2 control readback", d, 'h603);
    rd(3, d); chk("R2 flip readback", d, 30);
    chk("R9 live waits for boundary", int'(vrr_live), 0);
    wait_frame();
    chk("R10 old timing kept in write frame", last_len, 20);
    chk("R9 live at boundary", int'(vrr_live), 1);

    wait_frame();
    chk("R3 no push length", last_len, 60);
    chk("R3 no push latch line", last_latch, 54);

    wr(4, 3);
    rd(4, d); chk("R7 send reads set", d, 3);
    wait_frame();
    chk("R4 early push clamps to flip", last_len, 31);
    chk("R4 latch at earliest line", last_latch, 25);
    rd(4, d); chk("R7 send cleared after use", (d >> 1) & 1, 0);
    @(negedge clk);
    chk("R6 frame_start single cycle", int'(frame_start), 0);

    do @(negedge clk); while (cur_line != 13'd40);
    wr(4, 3);
    wait_frame();
    chk("R5 mid-window length", last_len, 47);
    chk("R5 mid-window latch line", last_latch, 41);

    wr(3, 40); wr(0, 'h601);
    wait_frame();
    chk("R10 frame of write unchanged", last_len, 60);
    wr(4, 3);
    wait_frame();
    chk("R11 flip disabled uses minimum", last_len, 31);
    wr(0, 'h603); wr(4, 3);
    wait_frame();
    chk("R11 still disabled in write frame", last_len, 31);
    wr(4, 3);
    wait_frame();
    chk("R11 flip enabled uses flip", last_len, 41);
    chk("R11 latch line", last_latch, 35);

    wr(0, 'h003);
    wait_frame();
    chk("R12 old guardband frame", last_len, 60);
    wait_frame();
    chk("R12 zero guardband length", last_len, 60);
    chk("R12 zero guardband latch", last_latch, 59);

    wr(0, 'h002);
    rd(5, d); chk("R9 status held after disable", d, 1);
    wait_frame();
    chk("R9 live cleared at boundary", int'(vrr_live), 0);
    rd(5, d); chk("R9 status cleared", d, 0);
    wr(4, 3);
    rd(4, d); chk("R8 push ignored after disable", (d >> 1) & 1, 0);
    wait_frame();
    chk("R8 length after disable", last_len, 60);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule